// File: doc/BRIEF.md
# Long-Press Button Action Controller

This block times how long a debounced, active-low push button is held and, once the hold reaches a programmable threshold, issues exactly one configured action request. The action is one of three: a hardware reset request (a power cycle followed by automatic wake), a ship-mode entry request, or nothing. Time is counted in ticks of an external one-millisecond enable strobe. A warning flag and an interrupt are raised at a programmable lead time before the threshold, so the host can react before the action fires.

The host programs the block through a small register interface with two addresses. The control word holds the action code, the hold threshold select, the warning lead select, a supply-gating enable and a software reset trigger. The flag word holds the sticky warning flag, which is cleared by writing one, and its interrupt mask. The host may retarget the action while the button is held. It can steer away from a hardware reset, but it cannot turn some other action into a reset mid-press. When gating is enabled, a reset also requires the input supply to stay valid for the whole press.

Top module: `lp_btn_ctrl`

## Requirements
- R1: After reset, address 0 and address 1 both read 0x00, `irq` is low, and no request pulse is produced.
- R2: A continuous press fires its action on the tick numbered HOLD_BASE + s*HOLD_STEP after the press began, where s is control bits [3:2]. The request pulse appears in the clock cycle after the posedge that consumed that tick. A press released earlier fires nothing.
- R3: The action field (control bits [1:0]) selects the action: 00 gives a pulse on `hw_rst_req`, 10 or 11 give a pulse on `ship_req`, and 01 gives no pulse.
- R4: Each press fires at most one action, however long the button is held. Releasing the button restarts the timing for the next press.
- R5: Flag bit 0 (address 1) becomes 1 on tick number threshold − (L+1)*LEAD_STEP of a press, where L is control bits [5:4]. It then stays 1 until the host clears it.
- R6: Writing address 1 with bit 0 set clears the warning flag. If that write falls in the same cycle as a new warning, the flag stays set.
- R7: `irq` equals the warning flag AND NOT the mask in flag bit 1 (address 1, read/write).
- R8: The action used is the field value at expiry. A rewrite during the press changes which action fires.
- R9: If the action field was not 00 when the press began, a mid-press rewrite to 00 produces no action for that press.
- R10: When control bit 6 is set, a long-press hardware reset fires only if `vin_ok` was high in every cycle of the press. A ship request is not gated by `vin_ok`.
- R11: Writing address 0 with bit 7 set produces one `hw_rst_req` pulse in the next cycle, whatever the button state. Bit 7 always reads 0. If this write falls in the same cycle as a long-press reset, a single pulse results.
- R12: Request pulses last one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle timing strobe, one per millisecond |
| btn_n | input | 1 | Debounced button, low while pressed |
| vin_ok | input | 1 | Input supply valid |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register address (0 control, 1 flags) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| hw_rst_req | output | 1 | One-cycle hardware reset request |
| ship_req | output | 1 | One-cycle ship-mode request |
| irq | output | 1 | Interrupt, high while an unmasked flag is set |

## Verification
Two pairs of functions can land in the same cycle. The first is a write-one-to-clear of the warning flag arriving in the cycle that the warning tick sets it. The bench provokes this by issuing the clear write at the exact negedge before the posedge that consumes the warning tick, and then requires the flag to read 1. The second is a software reset write coinciding with a long-press expiry. Here the scoreboard expects exactly one reset pulse, or a combined reset-plus-ship event when the pending action is ship, and it flags any extra pulse as unexpected.

// File: rtl/lp_pkg.sv
package lp_pkg;

   typedef enum logic [1:0] {
      ACT_HWRST = 2'b00,
      ACT_NONE  = 2'b01,
      ACT_SHIPA = 2'b10,
      ACT_SHIPB = 2'b11
   } lp_act_e;

   typedef struct packed {
      logic       sw_rst;
      logic       vin_gate;
      logic [1:0] lead_sel;
      logic [1:0] hold_sel;
      logic [1:0] act;
   } lp_ctrl_t;

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_FLAG = 1'b1;
   localparam int   FLG_WARN  = 0;
   localparam int   FLG_MASK  = 1;

endpackage

// File: rtl/lp_regs.sv
module lp_regs
   import lp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic       addr,
   input  logic [7:0] wdata,
   input  logic       warn_set,
   output logic [7:0] rdata,
   output lp_ctrl_t   ctrl,
   output logic       sw_rst,
   output logic       warn_flag,
   output logic       warn_mask
);

   lp_ctrl_t ctrl_q;
   logic     flag_q;
   logic     mask_q;
   logic     wr_ctrl;
   logic     wr_flag;
   logic     clr_req;

   assign wr_ctrl = we && (addr == ADDR_CTRL);
   assign wr_flag = we && (addr == ADDR_FLAG);
   assign clr_req = wr_flag && wdata[FLG_WARN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q        <= lp_ctrl_t'(wdata);
            ctrl_q.sw_rst <= 1'b0;
         end
         if (wr_flag) begin
            mask_q <= wdata[FLG_MASK];
         end
      end
   end

   // a new warning outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (warn_set) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   always_comb begin
      if (addr == ADDR_FLAG) begin
         rdata = {6'd0, mask_q, flag_q};
      end else begin
         rdata = ctrl_q;
      end
   end

   assign ctrl      = ctrl_q;
   assign sw_rst    = wr_ctrl && wdata[7];
   assign warn_flag = flag_q;
   assign warn_mask = mask_q;

endmodule

// File: rtl/lp_timer.sv
module lp_timer #(
   parameter int HOLD_BASE = 8000,
   parameter int HOLD_STEP = 2000,
   parameter int LEAD_STEP = 500,
   parameter int CW        = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       press,
   input  logic [1:0] hold_sel,
   input  logic [1:0] lead_sel,
   output logic       warn_hit,
   output logic       expire
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   logic [CW-1:0] hold_lim;
   logic [CW-1:0] warn_at;
   logic          fired_q;
   logic          active;

   assign hold_lim = CW'(HOLD_BASE + int'(hold_sel) * HOLD_STEP);
   assign warn_at  = hold_lim - CW'((int'(lead_sel) + 1) * LEAD_STEP);
   assign cnt_inc  = cnt_q + CW'(1);
   assign active   = press && tick && !fired_q;
   assign expire   = active && (cnt_inc >= hold_lim);
   assign warn_hit = active && (cnt_inc == warn_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (!press) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (active) begin
         cnt_q <= cnt_inc;
         if (expire) begin
            fired_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/lp_action.sv
module lp_action
   import lp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       press,
   input  logic       vin_ok,
   input  logic [1:0] act,
   input  logic       vin_gate,
   input  logic       expire,
   input  logic       sw_rst,
   output logic       hw_req,
   output logic       ship_req
);

   logic press_q;
   logic arm_rst_q;
   logic vin_all_q;
   logic new_press;
   logic vin_now;
   logic lp_rst;
   logic lp_ship;

   assign new_press = press && !press_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         press_q   <= 1'b0;
         arm_rst_q <= 1'b0;
         vin_all_q <= 1'b0;
      end else begin
         press_q <= press;
         if (new_press) begin
            arm_rst_q <= (act == ACT_HWRST);
            vin_all_q <= vin_ok;
         end else if (press) begin
            vin_all_q <= vin_all_q && vin_ok;
         end
      end
   end

   assign vin_now = new_press ? vin_ok : (vin_all_q && vin_ok);
   assign lp_rst  = expire && (act == ACT_HWRST) && arm_rst_q &&
                    (!vin_gate || vin_now);
   assign lp_ship = expire && act[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hw_req   <= 1'b0;
         ship_req <= 1'b0;
      end else begin
         hw_req   <= lp_rst || sw_rst;
         ship_req <= lp_ship;
      end
   end

endmodule

// File: rtl/lp_btn_ctrl.sv
module lp_btn_ctrl
   import lp_pkg::*;
#(
   parameter int HOLD_BASE = 8000,
   parameter int HOLD_STEP = 2000,
   parameter int LEAD_STEP = 500,
   parameter int VIN_SYNC  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic       btn_n,
   input  logic       vin_ok,
   input  logic       cfg_we,
   input  logic       cfg_addr,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_rdata,
   output logic       hw_rst_req,
   output logic       ship_req,
   output logic       irq
);

   localparam int MAX_HOLD = HOLD_BASE + 3 * HOLD_STEP;
   localparam int CW       = $clog2(MAX_HOLD + 1);

   if (HOLD_BASE < 1) begin : g_bad_base
      $error("HOLD_BASE must be positive");
   end
   if (4 * LEAD_STEP >= HOLD_BASE) begin : g_bad_lead
      $error("largest lead time must be below the shortest hold");
   end
   if (VIN_SYNC != 0 && VIN_SYNC != 1) begin : g_bad_sync
      $error("VIN_SYNC must be 0 or 1");
   end

   lp_ctrl_t ctrl;
   logic     sw_rst;
   logic     warn_flag;
   logic     warn_mask;
   logic     warn_hit;
   logic     expire;
   logic     vin_s;
   logic     press;

   assign press = !btn_n;

   if (VIN_SYNC == 1) begin : g_vin_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= 2'b00;
         end else begin
            sync_q <= {sync_q[0], vin_ok};
         end
      end
      assign vin_s = sync_q[1];
   end else begin : g_vin_direct
      assign vin_s = vin_ok;
   end

   lp_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .warn_set  (warn_hit),
      .rdata     (cfg_rdata),
      .ctrl      (ctrl),
      .sw_rst    (sw_rst),
      .warn_flag (warn_flag),
      .warn_mask (warn_mask)
   );

   lp_timer #(
      .HOLD_BASE (HOLD_BASE),
      .HOLD_STEP (HOLD_STEP),
      .LEAD_STEP (LEAD_STEP),
      .CW        (CW)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_ms),
      .press    (press),
      .hold_sel (ctrl.hold_sel),
      .lead_sel (ctrl.lead_sel),
      .warn_hit (warn_hit),
      .expire   (expire)
   );

   lp_action u_action (
      .clk      (clk),
      .rst_n    (rst_n),
      .press    (press),
      .vin_ok   (vin_s),
      .act      (ctrl.act),
      .vin_gate (ctrl.vin_gate),
      .expire   (expire),
      .sw_rst   (sw_rst),
      .hw_req   (hw_rst_req),
      .ship_req (ship_req)
   );

   assign irq = warn_flag && !warn_mask;

endmodule

// File: rtl/lp_btn_ctrl_chk.sv
module lp_btn_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       btn_n,
   input logic       cfg_we,
   input logic       cfg_addr,
   input logic [7:0] cfg_wdata,
   input logic       hw_rst_req,
   input logic       ship_req,
   input logic       irq,
   input logic       flag,
   input logic       mask
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
      end else if (btn_n) begin
         armed_q <= 1'b1;
      end else if (ship_req) begin
         armed_q <= 1'b0;
      end
   end

   // R11
   sw_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 1'b0 && cfg_wdata[7]) |=> hw_rst_req);

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(cfg_we && cfg_addr == 1'b1 && cfg_wdata[0])) |=> flag);

   // R7
   mask_gates_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask |-> !irq);

   // R4
   single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ship_req |-> armed_q);

   // R2
   ship_needs_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ship_req |-> $past(!btn_n));

   // R2
   hw_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_rst_req |-> ($past(!btn_n) || $past(cfg_we && cfg_addr == 1'b0 && cfg_wdata[7])));

   // R12
   ship_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ship_req |=> !ship_req);

endmodule

bind lp_btn_ctrl lp_btn_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .btn_n      (btn_n),
   .cfg_we     (cfg_we),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .hw_rst_req (hw_rst_req),
   .ship_req   (ship_req),
   .irq        (irq),
   .flag       (warn_flag),
   .mask       (warn_mask)
);

// File: tb/tb_lp_btn_ctrl.sv
module tb_lp_btn_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int HB = 40;
   localparam int HS = 10;
   localparam int LS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic       btn_n = 1'b1;
   logic       vin_ok = 1'b1;
   logic       cfg_we = 1'b0;
   logic       cfg_addr = 1'b0;
   logic [7:0] cfg_wdata = 8'd0;
   logic [7:0] cfg_rdata;
   logic       hw_rst_req;
   logic       ship_req;
   logic       irq;
   logic [1:0] div = 2'd0;

   int total = 0;
   int bad = 0;

   typedef struct {
      logic [1:0] kind;   // bit1 reset request, bit0 ship request
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   lp_btn_ctrl #(
      .HOLD_BASE (HB),
      .HOLD_STEP (HS),
      .LEAD_STEP (LS),
      .VIN_SYNC  (0)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_ms    (tick_ms),
      .btn_n      (btn_n),
      .vin_ok     (vin_ok),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .hw_rst_req (hw_rst_req),
      .ship_req   (ship_req),
      .irq        (irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always_ff @(posedge clk) begin
      div     <= div + 2'd1;
      tick_ms <= (div == 2'd3);
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic expect_evt(input logic [1:0] kind, input string tag);
      exp_t e;
      e.kind = kind;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (hw_rst_req || ship_req)) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected request", {30'd0, hw_rst_req, ship_req}, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, {30'd0, hw_rst_req, ship_req}, {30'd0, e.kind});
         end
      end
   end

   task automatic reg_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic reg_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   // hold the button for n consumed ticks; optional write and supply drop
   task automatic press(input int n, input int wr_at, input logic wa,
                        input logic [7:0] wd, input int drop_at);
      int k;
      do @(negedge clk); while (tick_ms);
      btn_n = 1'b0;
      k = 0;
      while (k < n) begin
         @(negedge clk);
         cfg_we = 1'b0;
         vin_ok = 1'b1;
         if (tick_ms) begin
            k++;
            if (k == wr_at) begin
               cfg_we    = 1'b1;
               cfg_addr  = wa;
               cfg_wdata = wd;
            end
            if (k == drop_at) vin_ok = 1'b0;
         end
      end
      @(negedge clk);
      cfg_we = 1'b0;
      vin_ok = 1'b1;
   endtask

   task automatic release_btn();
      btn_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic simple_press(input int n);
      press(n, -1, 1'b0, 8'd0, -1);
      release_btn();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(1'b0, rd); check("R1 ctrl reset", rd, 8'h00);
      reg_read(1'b1, rd); check("R1 flag reset", rd, 8'h00);
      check("R1 irq reset", irq, 0);
      check("R1 no pulse", {hw_rst_req, ship_req}, 0);

      // R2 no action one tick short; warning already passed (R5)
      simple_press(HB - 1);
      reg_read(1'b1, rd); check("R5 flag after long hold", rd, 8'h01);
      reg_write(1'b1, 8'h01);
      reg_read(1'b1, rd); check("R6 clear", rd, 8'h00);
      expect_evt(2'b10, "R2 reset at threshold");
      press(HB, -1, 1'b0, 8'd0, -1);
      check("R2 pulse cycle", hw_rst_req, 1);
      release_btn();

      // R3 action decode, threshold select 1
      reg_write(1'b0, 8'h06);
      simple_press(HB + HS - 1);
      expect_evt(2'b01, "R3 ship code 10");
      simple_press(HB + HS);
      reg_write(1'b0, 8'h07);
      expect_evt(2'b01, "R3 ship code 11");
      simple_press(HB + HS);
      reg_write(1'b0, 8'h05);
      simple_press(HB + HS);

      // R4 one action per long hold
      reg_write(1'b0, 8'h00);
      expect_evt(2'b10, "R4 single reset");
      simple_press(2 * HB);

      // R5 warning timing, lead select 3
      reg_write(1'b1, 8'h01);
      reg_write(1'b0, 8'h31);
      press(HB - 4 * LS - 1, -1, 1'b0, 8'd0, -1);
      reg_read(1'b1, rd); check("R5 flag not yet", rd, 8'h00);
      release_btn();
      press(HB - 4 * LS, -1, 1'b0, 8'd0, -1);
      reg_read(1'b1, rd); check("R5 flag at lead", rd, 8'h01);
      check("R7 irq set", irq, 1);
      release_btn();
      reg_write(1'b1, 8'h01);
      check("R6 irq after clear", irq, 0);

      // R7 mask
      reg_write(1'b1, 8'h02);
      simple_press(HB - 4 * LS);
      reg_read(1'b1, rd); check("R7 masked flag", rd, 8'h03);
      check("R7 masked irq", irq, 0);
      reg_write(1'b1, 8'h03);
      reg_read(1'b1, rd); check("R6 clear keeps mask", rd, 8'h02);
      reg_write(1'b1, 8'h00);

      // R6 clear colliding with warning set, lead select 0
      reg_write(1'b0, 8'h01);
      press(HB - LS, HB - LS, 1'b1, 8'h01, -1);
      reg_read(1'b1, rd); check("R6 set wins", rd, 8'h01);
      release_btn();
      reg_write(1'b1, 8'h01);

      // R8 mid-press retarget
      expect_evt(2'b01, "R8 none to ship");
      press(HB, 10, 1'b0, 8'h02, -1);
      release_btn();
      reg_write(1'b0, 8'h00);
      press(HB, 10, 1'b0, 8'h01, -1);
      release_btn();

      // R9 no escalation to reset
      reg_write(1'b0, 8'h02);
      press(HB, 10, 1'b0, 8'h00, -1);
      release_btn();
      expect_evt(2'b10, "R9 reset armed at press start");
      simple_press(HB);

      // R10 supply gating
      reg_write(1'b0, 8'h40);
      press(HB, -1, 1'b0, 8'd0, 20);
      release_btn();
      expect_evt(2'b10, "R10 gated reset supply steady");
      simple_press(HB);
      reg_write(1'b0, 8'h00);
      expect_evt(2'b10, "R10 ungated reset with drop");
      press(HB, -1, 1'b0, 8'd0, 20);
      release_btn();
      reg_write(1'b0, 8'h42);
      expect_evt(2'b01, "R10 ship not gated");
      press(HB, -1, 1'b0, 8'd0, 20);
      release_btn();

      // R11 software reset, R12 width
      reg_write(1'b0, 8'h01);
      expect_evt(2'b10, "R11 software reset");
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h81;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R11 pulse next cycle", hw_rst_req, 1);
      @(negedge clk);
      check("R12 pulse width", hw_rst_req, 0);
      reg_read(1'b0, rd); check("R11 trigger reads 0", rd, 8'h01);

      // R11 coincident with long-press expiry
      reg_write(1'b0, 8'h00);
      expect_evt(2'b10, "R11 merged reset");
      press(HB, HB, 1'b0, 8'h80, -1);
      release_btn();
      reg_write(1'b0, 8'h02);
      expect_evt(2'b11, "R11 reset with ship");
      press(HB, HB, 1'b0, 8'h82, -1);
      release_btn();

      repeat (20) @(negedge clk);
      check("R4 all expected requests seen", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule